// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash bus. After a write or erase command has been sent by other logic, a start pulse makes it read the device status byte over and over. It decides whether the operation has finished by comparing two reads in a row. It never trusts a single read.

In completion mode it reads the status byte in pairs. If the toggle bit is the same in both reads of a pair, the operation has finished. If the toggle bit differs and the exceeded-time flag is clear, it reads another pair. If the toggle bit differs and the exceeded-time flag is set, it reads one more pair, because toggling can stop just as that flag rises. A limit on the number of comparisons ends a run that never settles.

In query mode it reads one pair and reports two facts about the addressed sector. The toggle bit tells whether an erase is actively running. The sector toggle bit tells whether that sector is selected for erase. Reads go out through a request/acknowledge handshake to a bus master. That master handles all pin timing.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: After a synchronous reset the block is idle: `rd_req_o`, `busy_o`, `done_o`, `err_o`, `timeout_o`, `erasing_o` and `selected_o` are all 0.
- R2: A start accepted while idle raises `busy_o` and `rd_req_o`. No outcome is reported before two status reads of a pair have completed.
- R3: In completion mode, if bit 6 (toggle bit) is equal in both reads of a pair, the run ends with `done_o` and without `err_o`.
- R4: In completion mode, if bit 6 differs and bit 5 (time-exceeded flag) of the second read is 0, a fresh pair of reads follows, as long as the limit is not reached.
- R5: In completion mode, if bit 6 differs and bit 5 of the second read is 1, exactly one more pair is read. The run ends with `err_o` if bit 6 still differs in that pair, and without it otherwise.
- R6: If the `MAX_POLLS`-th comparison shows bit 6 differing with bit 5 clear, the run ends with `done_o`, `err_o` and `timeout_o`. `timeout_o` holds until the next start.
- R7: In query mode (`query_i`=1 at start), exactly one pair is read. `erasing_o` is set to whether bit 6 differed, `selected_o` to whether bit 2 (sector toggle bit) differed, and `err_o` stays 0.
- R8: `done_o` is a one-cycle pulse per run. `err_o` pulses only together with `done_o`.
- R9: `start_i` is ignored while `busy_o` is 1. The run in progress keeps its mode and its read sequence.
- R10: `rd_req_o` stays high until `rd_ack_i`. A read is taken only in a cycle where both are high, and `rd_data_i` is sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (ignored while busy) |
| query_i | input | 1 | Mode at start: 0 completion, 1 sector query |
| rd_req_o | output | 1 | Status read request to the bus master |
| rd_ack_i | input | 1 | Read completed; `rd_data_i` valid |
| rd_data_i | input | DW | Status byte |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | One-cycle failure pulse, coincident with `done_o` |
| timeout_o | output | 1 | Last run ended on the comparison limit |
| erasing_o | output | 1 | Query result: erase actively running |
| selected_o | output | 1 | Query result: sector selected for erase |

## Verification
The hardest case to reach is the exceeded-time recheck. It needs the flag rising in the second read of a toggling pair, and then toggling that either stops or continues in the very next pair. The bench's device model makes bit 6 toggle for a chosen number of reads and raises bit 5 from a chosen read index onward. It sweeps both numbers across every pair position, up to and past the comparison limit. The acknowledge latency is varied across runs so the same cases also occur with waits on the handshake.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_A  = 3'd1,
    ST_RD_B  = 3'd2,
    ST_RC_A  = 3'd3,
    ST_RC_B  = 3'd4
  } tbp_state_e;
endpackage

// File: rtl/tbp_pair_cmp.sv
module tbp_pair_cmp (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic cur_main_i,
  input  logic cur_sel_i,
  output logic tog_main_o,
  output logic tog_sel_o
);
  logic first_main_q;
  logic first_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_main_q <= 1'b0;
      first_sel_q  <= 1'b0;
    end else if (load_i) begin
      first_main_q <= cur_main_i;
      first_sel_q  <= cur_sel_i;
    end
  end

  assign tog_main_o = first_main_q ^ cur_main_i;
  assign tog_sel_o  = first_sel_q ^ cur_sel_i;
endmodule

// File: rtl/tbp_poll_cnt.sv
module tbp_poll_cnt #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inc_i |-> !last_o);
endmodule

// File: rtl/tbp_poll_ctrl.sv
module tbp_poll_ctrl #(
  parameter int DW        = 8,
  parameter int MAX_POLLS = 16,
  parameter int TOG_BIT   = 6,
  parameter int LIM_BIT   = 5,
  parameter int SEL_BIT   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          query_i,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          timeout_o,
  output logic          erasing_o,
  output logic          selected_o
);
  import tbp_pkg::*;

  tbp_state_e state_q;
  logic       is_qry_q;
  logic       xfer;
  logic       load_first;
  logic       tog_main;
  logic       tog_sel;
  logic       lim_flag;
  logic       cnt_last;
  logic       cnt_inc;
  logic       cnt_clr;
  logic       data_unused;

  assign data_unused = ^rd_data_i;
  assign xfer       = rd_req_o & rd_ack_i;
  assign lim_flag   = rd_data_i[LIM_BIT];
  assign load_first = xfer && (state_q == ST_RD_A || state_q == ST_RC_A);
  assign cnt_clr    = (state_q == ST_IDLE) && start_i;
  assign cnt_inc    = xfer && (state_q == ST_RD_B) && !is_qry_q &&
                      tog_main && !lim_flag && !cnt_last;

  tbp_pair_cmp cmp_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_first),
    .cur_main_i (rd_data_i[TOG_BIT]),
    .cur_sel_i  (rd_data_i[SEL_BIT]),
    .tog_main_o (tog_main),
    .tog_sel_o  (tog_sel)
  );

  tbp_poll_cnt #(.MAX_POLLS(MAX_POLLS)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      is_qry_q   <= 1'b0;
      rd_req_o   <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      timeout_o  <= 1'b0;
      erasing_o  <= 1'b0;
      selected_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_RD_A;
          is_qry_q   <= query_i;
          rd_req_o   <= 1'b1;
          busy_o     <= 1'b1;
          timeout_o  <= 1'b0;
          erasing_o  <= 1'b0;
          selected_o <= 1'b0;
        end
        ST_RD_A: if (xfer) state_q <= ST_RD_B;
        ST_RD_B: if (xfer) begin
          if (is_qry_q || !tog_main) begin
            erasing_o  <= is_qry_q & tog_main;
            selected_o <= is_qry_q & tog_sel;
            state_q    <= ST_IDLE;
            rd_req_o   <= 1'b0;
            busy_o     <= 1'b0;
            done_o     <= 1'b1;
          end else if (lim_flag) begin
            state_q <= ST_RC_A;
          end else if (cnt_last) begin
            state_q   <= ST_IDLE;
            rd_req_o  <= 1'b0;
            busy_o    <= 1'b0;
            done_o    <= 1'b1;
            err_o     <= 1'b1;
            timeout_o <= 1'b1;
          end else begin
            state_q <= ST_RD_A;
          end
        end
        ST_RC_A: if (xfer) state_q <= ST_RC_B;
        ST_RC_B: if (xfer) begin
          state_q  <= ST_IDLE;
          rd_req_o <= 1'b0;
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          err_o    <= tog_main;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);
  // R2
  req_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o);
  // R6
  timeout_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> err_o);
  // R9
  mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o && $past(busy_o)) |-> $stable(is_qry_q));
endmodule

// File: tb/tbp_poll_ctrl_tb.sv
`timescale 1ns/1ps
module tbp_poll_ctrl_tb_top;
  localparam int MAXP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       query_i = 1'b0;
  logic       rd_ack_i = 1'b0;
  logic [7:0] rd_data_i = 8'h00;
  logic rd_req_o, busy_o, done_o, err_o, timeout_o, erasing_o, selected_o;

  int checks = 0;
  int errors = 0;

  int cfg_t = 0, cfg_f = 99, lat = 0;
  logic cfg_qry = 1'b0, cfg_a = 1'b0, cfg_b = 1'b0;
  int idx = 0, waitc = 0;
  int nreads = 0, ndone = 0;
  logic saw_err = 1'b0;

  always #2 clk = ~clk;

  tbp_poll_ctrl #(.DW(8), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .query_i(query_i),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .timeout_o(timeout_o),
    .erasing_o(erasing_o), .selected_o(selected_o));

  function automatic logic [7:0] status_byte(int i);
    logic [7:0] v;
    v = 8'h00;
    if (cfg_qry) begin
      v[6] = cfg_a & i[0];
      v[2] = cfg_b & i[0];
    end else begin
      v[6] = ((i < cfg_t) ? i[0] : cfg_t[0]);
      v[5] = (i >= cfg_f);
      v[2] = i[0];
      v[0] = ~i[0];
    end
    return v;
  endfunction

  // device model: one-cycle ack after lat wait cycles
  always @(posedge clk) begin
    if (!busy_o) begin
      idx <= 0; waitc <= 0; rd_ack_i <= 1'b0;
    end else if (rd_ack_i) begin
      rd_ack_i <= 1'b0;
    end else if (rd_req_o) begin
      if (waitc >= lat) begin
        rd_ack_i  <= 1'b1;
        rd_data_i <= status_byte(idx);
        idx   <= idx + 1;
        waitc <= 0;
      end else waitc <= waitc + 1;
    end
  end

  always @(negedge clk) begin
    if (start_i && !busy_o) begin
      nreads <= 0; ndone <= 0; saw_err <= 1'b0;
    end else begin
      if (rd_req_o && rd_ack_i) nreads <= nreads + 1;
      if (done_o) ndone <= ndone + 1;
      if (err_o) saw_err <= 1'b1;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s T=%0d F=%0d act=%0d exp=%0d", tag, cfg_t, cfg_f, act, exp);
    end
  endtask

  task automatic expect_run(output int e_err, output int e_to, output int e_rd);
    e_err = 0; e_to = 0; e_rd = 0;
    for (int k = 0; k < MAXP; k++) begin
      if (2*k >= cfg_t) begin e_rd = 2*k + 2; return; end
      if (2*k + 1 >= cfg_f) begin
        e_rd = 2*k + 4; e_err = (2*k + 2 < cfg_t) ? 1 : 0; return;
      end
      if (k == MAXP - 1) begin e_rd = 2*k + 2; e_err = 1; e_to = 1; return; end
    end
  endtask

  task automatic do_run(logic q, logic poke);
    int guard;
    @(negedge clk);
    query_i = q; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; query_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 400) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 3) begin start_i = 1'b1; query_i = 1'b1; end
      else begin start_i = 1'b0; query_i = 1'b0; end
    end
    start_i = 1'b0;
    if (guard >= 400) check("watchdog", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int e_err, e_to, e_rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 idle outputs",
          {rd_req_o, busy_o, done_o, err_o, timeout_o, erasing_o, selected_o}, 0);

    // R2 R3 R4 R5 R6 R8 R10 completion sweep
    cfg_qry = 1'b0;
    for (int t = 0; t <= 10; t++) begin
      for (int f = 0; f <= 11; f++) begin
        cfg_t = t; cfg_f = (f == 11) ? 99 : f; lat = (t + f) % 3;
        expect_run(e_err, e_to, e_rd);
        do_run(1'b0, 1'b0);
        check("R3 R5 err", int'(saw_err), e_err);
        check("R6 timeout", int'(timeout_o), e_to);
        check("R2 R4 R10 reads", nreads, e_rd);
        check("R8 done pulses", ndone, 1);
      end
    end

    // R9 start during a run is ignored
    cfg_t = 5; cfg_f = 99; lat = 1;
    expect_run(e_err, e_to, e_rd);
    do_run(1'b0, 1'b1);
    check("R9 reads", nreads, e_rd);
    check("R9 done pulses", ndone, 1);
    check("R9 mode kept", int'(erasing_o | selected_o), 0);

    // R7 query mode
    cfg_qry = 1'b1;
    for (int c = 0; c < 4; c++) begin
      cfg_a = c[0]; cfg_b = c[1]; lat = c % 3;
      do_run(1'b1, 1'b0);
      check("R7 erasing", int'(erasing_o), c[0]);
      check("R7 selected", int'(selected_o), c[1]);
      check("R7 reads", nreads, 2);
      check("R7 no err", int'(saw_err), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule